// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

This block is a 32-bit down-counter for one processing unit. Software loads a start value, picks a clock divide ratio and programs a control entry. The entry holds the interrupt vector, a delivery-mode field, a mask and a one-shot/periodic selector. Writing the start value restarts the count. The count then drops by one on every prescaled tick, and software can read the remaining value at any time.

When the count expires, the timer emits a one-cycle request that carries the programmed vector and delivery mode, unless the entry is masked. In one-shot mode the counter stops at zero. In periodic mode the counter passes through zero and reloads, so a run of init+1 ticks makes one period. The interrupt controller that consumes the request lies outside this block.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (masked), the start value, the current count and the divide setting all read 0, and `irq_o` is low.
- R2: A write with `sel_i`=3 stores only bits 0, 1 and 3 of `wdata_i`. Reading select 3 returns that masked value.
- R3: The divide code is the 3-bit value {bit3, bit1, bit0} of the divide setting. The prescale shift is (code+1) mod 8, and the count drops once every 2^shift clocks. Code 111 therefore decrements every clock, and code 110 decrements every 128 clocks.
- R4: A write with `sel_i`=1 records the start value (readable at select 1), loads it into the current count and restarts the prescaler. The first decrement lands 2^shift clocks after the write edge.
- R5: In one-shot mode (entry bit 17 = 0), the current count (select 2) equals the start value minus the elapsed ticks, held at 0 once it gets there.
- R6: In periodic mode (entry bit 17 = 1), the current count equals the start value minus (elapsed ticks mod (start+1)).
- R7: An unmasked expiry raises `irq_o` for exactly one cycle, in the cycle after the tick edge at which a one-shot count reaches 0 or a periodic count wraps from 0. `irq_vector_o` carries entry bits 7:0 and `irq_mode_o` carries entry bits 10:8. The entry sits at select 0.
- R8: When entry bit 16 (mask) is set, no request is issued, and counting carries on unchanged.
- R9: A write to the entry acts on the running timer from the next tick on, without a restart: masking stops the requests and unmasking resumes them.
- R10: A start value of 0 stops the timer: the count stays 0 and no request is issued.
- R11: Writes with `sel_i`=2 (current count) are ignored. The count continues as if no write had occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select: 0 entry, 1 start value, 2 current count, 3 divide |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | One-cycle expiry request |
| irq_vector_o | output | 8 | Vector sent with the request |
| irq_mode_o | output | 3 | Delivery mode sent with the request |

## Verification
The hardest case to reach is an entry change that lands partway through a running periodic sequence. Whether a request appears depends on the mask at the exact wrap edge, and the write edge itself still sees the old entry. The bench counts cycles from each start-value write, so it knows where every wrap falls, and it places the mask and unmask writes between wraps. The slow divide codes are also checked one clock either side of their decrement edge, which exposes any error of one in the prescaler phase.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_CUR   = 2'd2,
    SEL_DIV   = 2'd3
  } reg_sel_e;

  localparam int SHIFT_W      = 3;
  localparam int MODE_LSB     = 8;
  localparam int MASK_BIT     = 16;
  localparam int PERIODIC_BIT = 17;
  localparam int DIV_W        = 4;
endpackage

// File: rtl/cdt_prescaler.sv
`timescale 1ns/1ps
module cdt_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] phase_mask;

  // all ones in the low 'shift' bits; shift of PRE_W wraps to all ones
  assign phase_mask = (PRE_W'(1) << shift_i) - PRE_W'(1);
  assign tick_o     = (pre_q & phase_mask) == phase_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else                pre_q <= pre_q + PRE_W'(1);
  end

  // R4
  restart_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && shift_i != '0) |=> !tick_o);
endmodule

// File: rtl/cdt_counter.sv
`timescale 1ns/1ps
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] init_o,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] init_q, cur_q;
  logic             run;

  assign run      = tick_i && (init_q != '0) && !load_i;
  assign expire_o = run && (periodic_i ? (cur_q == '0) : (cur_q == CNT_W'(1)));
  assign init_o   = init_q;
  assign cur_o    = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      cur_q  <= '0;
    end else if (load_i) begin
      init_q <= load_val_i;
      cur_q  <= load_val_i;
    end else if (run) begin
      if (cur_q != '0)     cur_q <= cur_q - CNT_W'(1);
      else if (periodic_i) cur_q <= init_q;
    end
  end

  // R5
  oneshot_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !periodic_i) |=> (cur_q <= $past(cur_q)));
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> (cur_q == $past(cur_q)));
  // R10
  zero_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q == '0 && !load_i) |=> (cur_q == $past(cur_q)));
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vector_o,
  output logic [MODE_W-1:0] irq_mode_o
);
  localparam logic [CNT_W-1:0] ENTRY_KEEP =
      (CNT_W'(1) << PERIODIC_BIT) | (CNT_W'(1) << MASK_BIT) |
      (CNT_W'((1 << MODE_W) - 1) << MODE_LSB) | CNT_W'((1 << VEC_W) - 1);
  localparam logic [CNT_W-1:0] ENTRY_RST  = CNT_W'(1) << MASK_BIT;
  localparam logic [DIV_W-1:0] DIV_KEEP   = DIV_W'(4'hB);

  logic [CNT_W-1:0]   entry_q;
  logic [DIV_W-1:0]   div_q;
  logic [SHIFT_W-1:0] shift;
  logic               load, tick, expire;
  logic [CNT_W-1:0]   init_val, cur_val;
  reg_sel_e           sel;

  assign sel   = reg_sel_e'(sel_i);
  assign load  = wr_i && (sel == SEL_INIT);
  // code {b3,b1,b0}; shift = code + 1, modulo 8
  assign shift = {div_q[3], div_q[1:0]} + SHIFT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= ENTRY_RST;
      div_q   <= '0;
    end else if (wr_i) begin
      if (sel == SEL_ENTRY) entry_q <= wdata_i & ENTRY_KEEP;
      if (sel == SEL_DIV)   div_q   <= wdata_i[DIV_W-1:0] & DIV_KEEP;
    end
  end

  cdt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load),
    .shift_i   (shift),
    .tick_o    (tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (wdata_i),
    .tick_i     (tick),
    .periodic_i (entry_q[PERIODIC_BIT]),
    .init_o     (init_val),
    .cur_o      (cur_val),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o        <= 1'b0;
      irq_vector_o <= '0;
      irq_mode_o   <= '0;
    end else begin
      irq_o <= expire && !entry_q[MASK_BIT];
      if (expire && !entry_q[MASK_BIT]) begin
        irq_vector_o <= entry_q[VEC_W-1:0];
        irq_mode_o   <= entry_q[MODE_LSB +: MODE_W];
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ENTRY: rdata_o = entry_q;
      SEL_INIT:  rdata_o = init_val;
      SEL_CUR:   rdata_o = cur_val;
      default:   rdata_o = CNT_W'(div_q);
    endcase
  end

  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R8
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(entry_q[MASK_BIT]));
endmodule

// File: tb/cdt_timer_test.sv
`timescale 1ns/1ps
module cdt_timer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic [7:0]  irq_vector_o;
  logic [2:0]  irq_mode_o;

  int tests = 0, fails = 0, pulses = 0;
  logic [7:0] last_vec = '0;
  logic [2:0] last_mode = '0;

  always #2.5 clk = ~clk;

  cdt_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .sel_i(sel_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .irq_vector_o(irq_vector_o), .irq_mode_o(irq_mode_o)
  );

  always @(negedge clk) if (irq_o) begin
    pulses++;
    last_vec  = irq_vector_o;
    last_mode = irq_mode_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); wr_i = 1'b1; sel_i = s; wdata_i = d;
    @(negedge clk); wr_i = 1'b0; #1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic read_reg(input logic [1:0] s, output logic [31:0] d);
    sel_i = s; #0.5; d = rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    read_reg(2'd0, v); check("R1 entry", v, 32'h0001_0000);
    read_reg(2'd1, v); check("R1 init", v, 0);
    read_reg(2'd2, v); check("R1 cur", v, 0);
    read_reg(2'd3, v); check("R1 div", v, 0);
    check("R1 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_div_mask;
    logic [31:0] v;
    write_reg(2'd3, 32'hFFFF_FFFF);
    read_reg(2'd3, v); check("R2 keep bits 0,1,3", v, 32'hB);
  endtask

  task automatic t_div_rates;
    logic [31:0] v;
    write_reg(2'd0, 32'h0001_0000);
    write_reg(2'd3, 32'hB);            // code 111 -> every clock
    write_reg(2'd1, 10);
    wait_cyc(4); read_reg(2'd2, v); check("R3 code111", v, 6);
    write_reg(2'd3, 32'h3);            // code 011 -> shift 4
    write_reg(2'd1, 10);
    wait_cyc(40); read_reg(2'd2, v); check("R3 code011 40", v, 8);
    wait_cyc(8);  read_reg(2'd2, v); check("R3 code011 48", v, 7);
    write_reg(2'd3, 32'h8);            // code 100 -> shift 5
    write_reg(2'd1, 10);
    wait_cyc(95); read_reg(2'd2, v); check("R3 code100 95", v, 8);
    wait_cyc(1);  read_reg(2'd2, v); check("R3 code100 96", v, 7);
    write_reg(2'd3, 32'hA);            // code 110 -> shift 7
    write_reg(2'd1, 4);
    wait_cyc(127); read_reg(2'd2, v); check("R3 code110 127", v, 4);
    wait_cyc(1);   read_reg(2'd2, v); check("R3 code110 128", v, 3);
  endtask

  task automatic t_load_restart;
    logic [31:0] v;
    write_reg(2'd3, 32'h0);            // code 000 -> shift 1
    write_reg(2'd1, 10);
    read_reg(2'd1, v); check("R4 init readback", v, 10);
    wait_cyc(1); read_reg(2'd2, v); check("R4 first edge", v, 10);
    wait_cyc(1); read_reg(2'd2, v); check("R4 first tick", v, 9);
    wait_cyc(5);
    write_reg(2'd1, 20);
    read_reg(2'd2, v); check("R4 reload", v, 20);
    wait_cyc(1); read_reg(2'd2, v); check("R4 restart phase", v, 20);
    wait_cyc(1); read_reg(2'd2, v); check("R4 restart tick", v, 19);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    write_reg(2'd3, 32'hB);
    write_reg(2'd0, 32'h0001_0000);
    write_reg(2'd1, 3);
    wait_cyc(2);  read_reg(2'd2, v); check("R5 mid", v, 1);
    wait_cyc(10); read_reg(2'd2, v); check("R5 saturate", v, 0);
  endtask

  task automatic t_fire;
    int p0;
    write_reg(2'd3, 32'hB);
    write_reg(2'd0, 32'h0000_0242);
    write_reg(2'd1, 5);
    p0 = pulses;
    wait_cyc(4); check("R7 not early", {31'd0, irq_o}, 0);
    wait_cyc(1); check("R7 fire", {31'd0, irq_o}, 1);
    check("R7 vector", {24'd0, irq_vector_o}, 32'h42);
    check("R7 mode", {29'd0, irq_mode_o}, 2);
    wait_cyc(1); check("R7 one cycle", {31'd0, irq_o}, 0);
    wait_cyc(10); check("R7 single pulse", pulses - p0, 1);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    int p0;
    write_reg(2'd3, 32'hB);
    write_reg(2'd0, 32'h0002_0555);
    write_reg(2'd1, 3);
    p0 = pulses;
    wait_cyc(20); read_reg(2'd2, v); check("R6 wrap value", v, 3);
    check("R7 periodic pulses", pulses - p0, 5);
    check("R7 periodic vector", {24'd0, last_vec}, 32'h55);
    check("R7 periodic mode", {29'd0, last_mode}, 5);
    wait_cyc(2); read_reg(2'd2, v); check("R6 mid period", v, 1);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    int p0;
    write_reg(2'd3, 32'hB);
    write_reg(2'd0, 32'h0001_0033);
    write_reg(2'd1, 3);
    p0 = pulses;
    wait_cyc(10); check("R8 no pulse", pulses - p0, 0);
    read_reg(2'd2, v); check("R8 still counts", v, 0);
  endtask

  task automatic t_live_entry;
    int p0;
    write_reg(2'd3, 32'hB);
    write_reg(2'd0, 32'h0002_0011);
    write_reg(2'd1, 2);                // wraps every 3 clocks
    p0 = pulses;
    wait_cyc(6); check("R9 running", pulses - p0, 2);
    write_reg(2'd0, 32'h0003_0011);
    p0 = pulses;
    wait_cyc(12); check("R9 masked live", pulses - p0, 0);
    write_reg(2'd0, 32'h0002_0011);
    p0 = pulses;
    wait_cyc(6); check("R9 unmasked live", pulses - p0, 2);
  endtask

  task automatic t_zero_init;
    logic [31:0] v;
    int p0;
    write_reg(2'd3, 32'hB);
    write_reg(2'd0, 32'h0002_0077);
    write_reg(2'd1, 0);
    p0 = pulses;
    wait_cyc(50); check("R10 no pulse", pulses - p0, 0);
    read_reg(2'd2, v); check("R10 stays zero", v, 0);
  endtask

  task automatic t_cur_ro;
    logic [31:0] v;
    write_reg(2'd3, 32'hB);
    write_reg(2'd0, 32'h0001_0000);
    write_reg(2'd1, 100);
    write_reg(2'd2, 5);
    read_reg(2'd2, v); check("R11 write ignored", v, 98);
    read_reg(2'd1, v); check("R11 init intact", v, 100);
  endtask

  bit done = 1'b0;

  initial begin
    #500000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_div_mask();
    t_div_rates();
    t_load_restart();
    t_oneshot();
    t_fire();
    t_periodic();
    t_masked();
    t_live_entry();
    t_zero_init();
    t_cur_ro();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule